// File: doc/BRIEF.md
# Clock Generator Watchdog with Safe Frequency Fallback

This block supervises a programmable clock generator. While armed, it counts down a timeout expressed in coarse time units; each unit is a parameterised number of pulses on a base time tick. Any host register access, or an explicit kick strobe, restarts the countdown. If the countdown runs out, the block does three things:

- it sets a sticky alarm status bit;
- it replaces the frequency-select code it passes on with a safe code;
- it drives an active-low system reset for a fixed number of ticks.

The safe code comes either from the select inputs latched at power-on or from a 5-bit programmed field. A control bit chooses between them.

The block holds two host-writable bytes:

- A timeout byte, whose value is the number of time units.
- A control byte, with this layout:

| Bits | Field |
|------|-------|
| [4:0] | Safe code field |
| [5] | Alarm status |
| [6] | Run enable |
| [7] | Safe-source select |

Both bytes can be read back at the ports. The PLL, the dividers and spread-spectrum generation sit elsewhere. This block only outputs the code those circuits should use.

Top module: `clkgen_watchdog`

## Requirements
- R1: After reset, the block is in this state:
  - timeout byte = 16;
  - control byte = 8'h1F (safe field all ones, alarm 0, enable 0, source select 0);
  - `rst_no_o` = 1;
  - `code_o` = `freq_code_i`.
- R2: While enabled, the timeout fires on the tick that completes max(N,1)·UNIT_TICKS ticks counted since the last reload, where N is the timeout byte. At the clock edge of that tick, the alarm becomes 1 and `rst_no_o` becomes 0.
- R3: A restart happens on any cycle with `kick_i`, `tmo_we_i` or `ctl_we_i` high. A restart discards the ticks counted so far, and a tick in that same cycle is not counted. A write to the timeout byte takes effect as the new N in the same restart.
- R4: While control bit 6 (enable) is 0, no timeout occurs and the alarm bit is held.
- R5: The alarm bit (control bit 5) stays at 1 until a control write with bit 5 = 0. A control write with bit 5 = 1 does not change the alarm bit.
- R6: After a timeout, `rst_no_o` stays 0 for exactly RST_TICKS further ticks, then returns to 1.
- R7: `code_o` depends on the alarm and source-select bits:

| Alarm (bit 5) | Source select (bit 7) | `code_o` |
|---|---|---|
| 0 | any | `freq_code_i` |
| 1 | 0 | `strap_code_i` |
| 1 | 1 | control bits [4:0] |

- R8: A timeout re-arms the countdown with the same N, so a watchdog that is not serviced fires again one full timeout later and restarts the reset pulse.
- R9: Reads and writes of the two bytes work as follows:
  - `tmo_o` shows the timeout byte, which changes only on `tmo_we_i`.
  - `ctl_o` shows bits [7:0] as source select, enable, alarm and the 5-bit safe field, from bit 7 down to bit 0.
  - A control write loads bits 7, 6 and [4:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base time tick strobe |
| kick_i | input | 1 | Host activity strobe, restarts the countdown |
| tmo_we_i | input | 1 | Timeout byte write strobe |
| tmo_wdata_i | input | 8 | Timeout byte write data |
| ctl_we_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte write data |
| strap_code_i | input | 5 | Frequency code latched at power-on |
| freq_code_i | input | 5 | Frequency code used in normal operation |
| tmo_o | output | 8 | Timeout byte readback |
| ctl_o | output | 8 | Control byte readback |
| code_o | output | 5 | Effective frequency code |
| alarm_o | output | 1 | Sticky alarm status |
| rst_no_o | output | 1 | Active-low system reset pulse |

## Verification
The assertions rely on two properties of the inputs. First, every register write also counts as a restart, so an alarm clear can never land in the same cycle as a timeout. Second, `tick_i` is a clean single-cycle strobe with no relation to the host strobes. The stimulus keeps within this by driving writes only through the defined strobes, with tick, kick and write rates drawn at random. The stimulus mostly keeps the enable bit set and the timeout byte small, so that timeouts, re-arms and overlapping reset pulses occur often. Directed sequences then cover the boundary cases: the default count, a count of zero, a kick one tick before expiry, and a run with enable cleared.

// File: rtl/wd_pkg.sv
`timescale 1ns/1ps
package wd_pkg;
  localparam int unsigned CODE_W = 5;

  typedef struct packed {
    logic              src_prog;
    logic              run_en;
    logic              alarm;
    logic [CODE_W-1:0] safe_code;
  } wd_ctl_t;

  localparam wd_ctl_t CTL_RESET = '{src_prog: 1'b0, run_en: 1'b0, alarm: 1'b0, safe_code: '1};
endpackage

// File: rtl/wd_regs.sv
`timescale 1ns/1ps
module wd_regs
  import wd_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned TMO_RESET = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tmo_we_i,
  input  logic [CNT_W-1:0] tmo_wdata_i,
  input  logic             ctl_we_i,
  input  wd_ctl_t          ctl_wdata_i,
  input  logic             expire_i,
  output logic [CNT_W-1:0] tmo_q_o,
  output wd_ctl_t          ctl_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q_o <= CNT_W'(TMO_RESET);
      ctl_q_o <= CTL_RESET;
    end else begin
      if (tmo_we_i) tmo_q_o <= tmo_wdata_i;
      if (ctl_we_i) begin
        ctl_q_o.src_prog  <= ctl_wdata_i.src_prog;
        ctl_q_o.run_en    <= ctl_wdata_i.run_en;
        ctl_q_o.safe_code <= ctl_wdata_i.safe_code;
      end
      // set wins; a write of 1 to the alarm bit is ignored
      if (expire_i)                             ctl_q_o.alarm <= 1'b1;
      else if (ctl_we_i && !ctl_wdata_i.alarm) ctl_q_o.alarm <= 1'b0;
    end
  end
endmodule

// File: rtl/wd_prescaler.sv
`timescale 1ns/1ps
module wd_prescaler #(
  parameter int unsigned UNIT_TICKS = 290
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic unit_o
);
  localparam int unsigned PW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(UNIT_TICKS - 1);

  logic [PW-1:0] pre_q;
  logic          at_last;

  assign at_last = (pre_q == LAST);
  assign unit_o  = run_i & tick_i & ~clr_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pre_q <= '0;
    else if (clr_i)           pre_q <= '0;
    else if (run_i && tick_i) pre_q <= at_last ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/wd_countdown.sv
`timescale 1ns/1ps
module wd_countdown #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned TMO_RESET = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] rearm_val_i,
  input  logic             unit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // a count of 0 behaves like 1
  assign expire_o = unit_i & ~reload_i & (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= CNT_W'(TMO_RESET);
    else if (reload_i) cnt_q <= load_val_i;
    else if (expire_o) cnt_q <= rearm_val_i;
    else if (unit_i)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wd_reset_pulse.sv
`timescale 1ns/1ps
module wd_reset_pulse #(
  parameter int unsigned RST_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic rst_no
);
  localparam int unsigned RW = $clog2(RST_TICKS + 1);

  logic [RW-1:0] left_q;

  assign rst_no = (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  left_q <= '0;
    else if (start_i)             left_q <= RW'(RST_TICKS);
    else if (tick_i && !rst_no)   left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/clkgen_watchdog.sv
`timescale 1ns/1ps
module clkgen_watchdog
  import wd_pkg::*;
#(
  parameter int unsigned UNIT_TICKS = 290,
  parameter int unsigned RST_TICKS  = 8,
  parameter int unsigned TMO_RESET  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              kick_i,
  input  logic              tmo_we_i,
  input  logic [7:0]        tmo_wdata_i,
  input  logic              ctl_we_i,
  input  logic [7:0]        ctl_wdata_i,
  input  logic [CODE_W-1:0] strap_code_i,
  input  logic [CODE_W-1:0] freq_code_i,
  output logic [7:0]        tmo_o,
  output logic [7:0]        ctl_o,
  output logic [CODE_W-1:0] code_o,
  output logic              alarm_o,
  output logic              rst_no_o
);
  localparam int unsigned CNT_W = 8;

  wd_ctl_t           ctl_q;
  logic [CNT_W-1:0]  tmo_q;
  logic [CNT_W-1:0]  load_val;
  logic              reload;
  logic              unit;
  logic              expire;
  logic [CODE_W-1:0] safe_sel;

  assign reload   = kick_i | tmo_we_i | ctl_we_i;
  assign load_val = tmo_we_i ? tmo_wdata_i : tmo_q;

  wd_regs #(.CNT_W(CNT_W), .TMO_RESET(TMO_RESET)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tmo_we_i    (tmo_we_i),
    .tmo_wdata_i (tmo_wdata_i),
    .ctl_we_i    (ctl_we_i),
    .ctl_wdata_i (wd_ctl_t'(ctl_wdata_i)),
    .expire_i    (expire),
    .tmo_q_o     (tmo_q),
    .ctl_q_o     (ctl_q)
  );

  wd_prescaler #(.UNIT_TICKS(UNIT_TICKS)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctl_q.run_en),
    .clr_i  (reload),
    .tick_i (tick_i),
    .unit_o (unit)
  );

  wd_countdown #(.CNT_W(CNT_W), .TMO_RESET(TMO_RESET)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reload_i    (reload),
    .load_val_i  (load_val),
    .rearm_val_i (tmo_q),
    .unit_i      (unit),
    .expire_o    (expire)
  );

  wd_reset_pulse #(.RST_TICKS(RST_TICKS)) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (expire),
    .tick_i  (tick_i),
    .rst_no  (rst_no_o)
  );

  assign safe_sel = ctl_q.src_prog ? ctl_q.safe_code : strap_code_i;
  assign code_o   = ctl_q.alarm ? safe_sel : freq_code_i;
  assign alarm_o  = ctl_q.alarm;
  assign tmo_o    = tmo_q;
  assign ctl_o    = ctl_q;
endmodule

// File: rtl/clkgen_watchdog_chk.sv
`timescale 1ns/1ps
module clkgen_watchdog_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       kick_i,
  input logic       tmo_we_i,
  input logic [7:0] tmo_wdata_i,
  input logic       ctl_we_i,
  input logic [7:0] ctl_wdata_i,
  input logic [4:0] strap_code_i,
  input logic [4:0] freq_code_i,
  input logic [7:0] tmo_o,
  input logic [7:0] ctl_o,
  input logic [4:0] code_o,
  input logic       alarm_o,
  input logic       rst_no_o
);
  AST_ALARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && !(ctl_we_i && !ctl_wdata_i[5])) |=> alarm_o); // R5

  AST_RST_FALL_ALARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_no_o) |-> alarm_o); // R6

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_o[6] && rst_no_o) |=> rst_no_o); // R4

  AST_KICK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && rst_no_o) |=> rst_no_o); // R3

  AST_CODE_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alarm_o |-> (code_o == freq_code_i)); // R7

  AST_TMO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmo_we_i |=> $stable(tmo_o)); // R9

  AST_ALARM_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o == ctl_o[5]); // R9
endmodule

bind clkgen_watchdog clkgen_watchdog_chk u_chk (.*);

// File: tb/tb_clkgen_watchdog.sv
`timescale 1ns/1ps
module tb_clkgen_watchdog;
  localparam int UT = 3;
  localparam int RT = 5;
  localparam int TMO_DEF = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0, kick = 1'b0, twe = 1'b0, cwe = 1'b0;
  logic [7:0] twd = '0, cwd = '0;
  logic [4:0] strap = 5'd9, fcode = 5'd3;
  logic [7:0] tmo_o, ctl_o;
  logic [4:0] code_o;
  logic       alarm_o, rst_no_o;

  always #10 clk = ~clk;

  clkgen_watchdog #(.UNIT_TICKS(UT), .RST_TICKS(RT), .TMO_RESET(TMO_DEF)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .kick_i(kick),
    .tmo_we_i(twe), .tmo_wdata_i(twd), .ctl_we_i(cwe), .ctl_wdata_i(cwd),
    .strap_code_i(strap), .freq_code_i(fcode),
    .tmo_o(tmo_o), .ctl_o(ctl_o), .code_o(code_o), .alarm_o(alarm_o), .rst_no_o(rst_no_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int       m_tmo = TMO_DEF;
  bit       m_en = 0, m_src = 0, m_alarm = 0;
  bit [4:0] m_safe = 5'h1F;
  int       m_ticks = 0, m_rst = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lim(input int n);
    return ((n < 1) ? 1 : n) * UT;
  endfunction

  task automatic model_update();
    bit reload, expire;
    reload = kick | twe | cwe;
    expire = 0;
    if (reload) m_ticks = 0;
    else if (m_en && tick) begin
      m_ticks++;
      if (m_ticks >= lim(m_tmo)) begin expire = 1; m_ticks = 0; end
    end
    if (expire) m_rst = RT;
    else if (tick && m_rst > 0) m_rst--;
    if (expire) m_alarm = 1;
    else if (cwe && !cwd[5]) m_alarm = 0;
    if (cwe) begin m_src = cwd[7]; m_en = cwd[6]; m_safe = cwd[4:0]; end
    if (twe) m_tmo = twd;
  endtask

  task automatic compare();
    bit [4:0] exp_code;
    exp_code = m_alarm ? (m_src ? m_safe : strap) : fcode;
    chk(tmo_o == 8'(m_tmo), "R9", "tmo_o", tmo_o, m_tmo);
    chk(ctl_o == {m_src, m_en, m_alarm, m_safe}, "R9", "ctl_o", ctl_o, {m_src, m_en, m_alarm, m_safe});
    chk(alarm_o == m_alarm, "R5", "alarm_o", alarm_o, m_alarm);
    chk(rst_no_o == (m_rst == 0), "R6", "rst_no_o", rst_no_o, (m_rst == 0));
    chk(code_o == exp_code, "R7", "code_o", code_o, exp_code);
  endtask

  task automatic cyc();
    @(posedge clk);
    #1 model_update();
    @(negedge clk);
    compare();
    kick = 0; twe = 0; cwe = 0;
  endtask

  task automatic idle(input int n, input bit t);
    for (int i = 0; i < n; i++) begin
      tick = t;
      cyc();
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    cwe = 1; cwd = v; tick = 1; cyc();
  endtask

  task automatic wr_tmo(input logic [7:0] v);
    twe = 1; twd = v; tick = 1; cyc();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tmo_o == 8'd16, "R1", "tmo_o reset", tmo_o, 16);
    chk(ctl_o == 8'h1F, "R1", "ctl_o reset", ctl_o, 8'h1F);
    chk(rst_no_o == 1'b1, "R1", "rst_no_o reset", rst_no_o, 1);
    chk(code_o == fcode, "R1", "code_o reset", code_o, fcode);
    rst_ni = 1'b1;
    idle(10, 1);
    chk(alarm_o == 1'b0, "R4", "alarm while disabled after reset", alarm_o, 0);

    // R2 default count 16 -> 48 ticks
    wr_ctl(8'h45);
    idle(lim(TMO_DEF) - 1, 1);
    chk(alarm_o == 1'b0, "R2", "alarm one tick early", alarm_o, 0);
    idle(1, 1);
    chk(alarm_o == 1'b1, "R2", "alarm at expiry", alarm_o, 1);
    chk(rst_no_o == 1'b0, "R2", "reset at expiry", rst_no_o, 0);
    chk(code_o == strap, "R7", "strap safe code", code_o, strap);

    // R6 pulse width
    idle(RT - 1, 1);
    chk(rst_no_o == 1'b0, "R6", "reset still low", rst_no_o, 0);
    idle(1, 1);
    chk(rst_no_o == 1'b1, "R6", "reset released", rst_no_o, 1);

    // R8 re-arm
    idle(lim(TMO_DEF) - RT - 1, 1);
    chk(rst_no_o == 1'b1, "R8", "no second reset yet", rst_no_o, 1);
    chk(alarm_o == 1'b1, "R5", "alarm sticky", alarm_o, 1);
    idle(1, 1);
    chk(rst_no_o == 1'b0, "R8", "second reset", rst_no_o, 0);

    // R5 write 1 ignored, write 0 clears; R7 programmed source
    wr_ctl(8'hE5);
    chk(alarm_o == 1'b1, "R5", "alarm after write 1", alarm_o, 1);
    chk(code_o == 5'd5, "R7", "programmed safe code", code_o, 5);
    wr_ctl(8'hC5);
    chk(alarm_o == 1'b0, "R5", "alarm cleared", alarm_o, 0);
    idle(10, 1);

    // R3 kick restarts
    wr_tmo(8'd2);
    idle(lim(2) - 1, 1);
    kick = 1; tick = 1; cyc();
    idle(lim(2) - 1, 1);
    chk(alarm_o == 1'b0, "R3", "no alarm after kick", alarm_o, 0);
    idle(1, 1);
    chk(alarm_o == 1'b1, "R3", "alarm full period after kick", alarm_o, 1);

    // R4 disabled: no expiry, alarm held
    wr_ctl(8'hA5);
    idle(100, 1);
    chk(rst_no_o == 1'b1, "R4", "no reset while disabled", rst_no_o, 1);
    chk(alarm_o == 1'b1, "R4", "alarm held while disabled", alarm_o, 1);

    // R2 count 0 behaves as 1
    wr_tmo(8'd0);
    wr_ctl(8'hC5);
    idle(UT - 1, 1);
    chk(alarm_o == 1'b0, "R2", "zero count early", alarm_o, 0);
    idle(1, 1);
    chk(alarm_o == 1'b1, "R2", "zero count expiry", alarm_o, 1);

    // random phase
    for (int i = 0; i < 15000; i++) begin
      tick  = ($urandom % 2) == 0;
      kick  = ($urandom % 100) < 3;
      strap = 5'($urandom);
      fcode = 5'($urandom);
      if (($urandom % 100) < 1) begin twe = 1; twd = 8'($urandom % 6); end
      if (($urandom % 100) < 2) begin
        cwe = 1;
        cwd = 8'($urandom);
        if (($urandom % 10) < 8) cwd[6] = 1'b1;
      end
      cyc();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule